// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Controller

This block sits between the clock generators of a programmable oscillator and its two output pins. It takes a reference clock source (either the undivided master-rate clock or a prescaled copy) and a main clock source, and decides whether each reaches its pin. It also decides whether the whole device shuts down. Two external control pins are the inputs to that decision, and four configuration bits set the meaning of each pin. Control pin 0 can be a reference-source select, an output enable for the reference output, or a shutdown input. Control pin 1 can be an output enable for the main output or a shutdown input.

All clock sources arrive as level signals sampled on the block clock. Each output is gated so that it never starts or ends in the middle of a high phase. A shutdown request must stay present for a parameterised number of cycles before it is accepted. When it is accepted, both outputs are first drained to Hi-Z and only then is the device reported as down. After reset, and after every exit from shutdown, both outputs stay in Hi-Z for a parameterised settling window before they may run.

Top module: `clkout_ctrl`

## Requirements
- R1: With cfg_pdn0=1, control pin 0 is a shutdown source whatever cfg_en0 holds. The reference output is enabled while that pin is low, and cfg_sel0 picks its source (0 selects the master-rate source, 1 selects the prescaled source).
- R2: With cfg_en0=1 and cfg_pdn0=0, control pin 0 is an output enable for the reference output only (1 gives Hi-Z, 0 enables it) and never causes shutdown. cfg_sel0 picks the source.
- R3: With cfg_en0=0, cfg_sel0=1 and cfg_pdn0=0, control pin 0 selects the reference source (mux_pick follows the pin; 1 means prescaled) and the reference output stays enabled.
- R4: With cfg_en0=cfg_sel0=cfg_pdn0=0, the reference output is held in Hi-Z at all times and control pin 0 is a shutdown source.
- R5: With cfg_pdn1=1, control pin 1 is a shutdown source. With cfg_pdn1=0, it is an output enable for the main output only (1 gives Hi-Z).
- R6: A device shutdown request is the OR of every control pin that its configuration makes a shutdown source.
- R7: An output changes between driven and Hi-Z only in a cycle where it is low. While enabled, it repeats its selected source one cycle late.
- R8: pwr_down is asserted only after both outputs are in Hi-Z.
- R9: After reset, and after pwr_down falls, both outputs stay in Hi-Z for at least SETTLE_CYC cycles.
- R10: A shutdown request shorter than PERSIST_CYC consecutive cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (master-rate sampling clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_mast | input | 1 | Master-rate reference source level |
| lvl_pre | input | 1 | Prescaled reference source level |
| lvl_main | input | 1 | Main output source level |
| ctl0_pin | input | 1 | External control pin 0 (asynchronous) |
| ctl1_pin | input | 1 | External control pin 1 (asynchronous) |
| cfg_en0 | input | 1 | Pin 0 acts as reference output enable |
| cfg_sel0 | input | 1 | Reference source choice / pin 0 select mode |
| cfg_pdn0 | input | 1 | Pin 0 acts as shutdown |
| cfg_pdn1 | input | 1 | Pin 1 acts as shutdown |
| out0 | output | 1 | Gated reference clock |
| out0_hiz | output | 1 | Reference output in Hi-Z |
| out1 | output | 1 | Gated main clock |
| out1_hiz | output | 1 | Main output in Hi-Z |
| mux_pick | output | 1 | Reference source select, 1 = prescaled |
| pwr_down | output | 1 | Device is in shutdown |

## Verification
The hardest state to reach is a clean shutdown exit. The bench needs a request that outlasts the persistence threshold, then a drain that has to wait for both sources to go low, and then the full settling window. The bench builds all of this with a small threshold and window. It sweeps every combination of the three pin-0 bits with both pin levels, and every pin-1 mode with both levels. Each case is released and allowed to recover before the next one starts. A short pulse below the threshold checks that a brief request is ignored. The gated outputs are compared, cycle by cycle, against source patterns that the bench computes from a cycle count.

// File: rtl/ctl_gate_pkg.sv
package ctl_gate_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DOWN  = 2'd3
  } seq_st_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pin_decode.sv
module pin_decode (
  input  logic ctl0_s,
  input  logic ctl1_s,
  input  logic en0,
  input  logic sel0,
  input  logic pdn0,
  input  logic pdn1,
  output logic ref_want,
  output logic main_want,
  output logic pick,
  output logic pd_req
);
  logic ref_pd_mode, ref_sel_mode;

  always_comb begin
    // pin 0 acts as shutdown when forced, or when all three bits are clear
    ref_pd_mode  = pdn0 | (~en0 & ~sel0);
    ref_sel_mode = ~pdn0 & ~en0 & sel0;
    pick         = ref_sel_mode ? ctl0_s : sel0;
    if (pdn0)      ref_want = 1'b1;
    else if (en0)  ref_want = ~ctl0_s;
    else           ref_want = sel0;
    main_want    = pdn1 ? 1'b1 : ~ctl1_s;
    pd_req       = (ref_pd_mode & ctl0_s) | (pdn1 & ctl1_s);
  end
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import ctl_gate_pkg::*;
#(
  parameter int PERSIST_CYC = 4096,
  parameter int SETTLE_CYC  = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic outs_off,
  output logic run_ok,
  output logic down
);
  localparam int PCW = $clog2(PERSIST_CYC + 1);
  localparam int SCW = $clog2(SETTLE_CYC + 1);

  seq_st_t        st_q, st_d;
  logic [PCW-1:0] pcnt_q;
  logic [SCW-1:0] scnt_q;
  logic           persist_hit;

  assign persist_hit = pd_req && (pcnt_q >= PCW'(PERSIST_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pcnt_q <= '0;
    else if (!pd_req)                       pcnt_q <= '0;
    else if (pcnt_q != PCW'(PERSIST_CYC))   pcnt_q <= pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               scnt_q <= '0;
    else if (st_q != ST_HOLD) scnt_q <= '0;
    else                      scnt_q <= scnt_q + 1'b1;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_HOLD:  if (persist_hit) st_d = ST_DRAIN;
                else if (scnt_q == SCW'(SETTLE_CYC - 1)) st_d = ST_RUN;
      ST_RUN:   if (persist_hit) st_d = ST_DRAIN;
      ST_DRAIN: if (outs_off) st_d = ST_DOWN;
      default:  if (!pd_req) st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HOLD;
    else        st_q <= st_d;
  end

  assign run_ok = (st_q == ST_RUN);
  assign down   = (st_q == ST_DOWN);

  assert_short_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) && !pd_req |=> st_q != ST_DRAIN);

  assert_down_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DOWN) && pd_req |=> st_q == ST_DOWN);
endmodule

// File: rtl/out_gate.sv
module out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic want,
  output logic out_q,
  output logic hiz_q
);
  logic on_q, nxt_on;

  // enable state may only move while the source is low
  always_comb begin
    nxt_on = on_q;
    if (!src) nxt_on = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      out_q <= 1'b0;
      hiz_q <= 1'b1;
    end else begin
      on_q  <= nxt_on;
      out_q <= nxt_on & src;
      hiz_q <= ~nxt_on;
    end
  end

  assert_switch_when_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hiz_q) |-> !out_q);
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int PERSIST_CYC = 4096,
  parameter int SETTLE_CYC  = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_mast,
  input  logic lvl_pre,
  input  logic lvl_main,
  input  logic ctl0_pin,
  input  logic ctl1_pin,
  input  logic cfg_en0,
  input  logic cfg_sel0,
  input  logic cfg_pdn0,
  input  logic cfg_pdn1,
  output logic out0,
  output logic out0_hiz,
  output logic out1,
  output logic out1_hiz,
  output logic mux_pick,
  output logic pwr_down
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_raw, pin_s, src_v, want_v, out_v, hiz_v;
  logic            ref_want, main_want, pd_req, run_ok;

  assign pin_raw = {ctl1_pin, ctl0_pin};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_s[g]));
  end

  pin_decode dec_i (
    .ctl0_s(pin_s[0]), .ctl1_s(pin_s[1]),
    .en0(cfg_en0), .sel0(cfg_sel0), .pdn0(cfg_pdn0), .pdn1(cfg_pdn1),
    .ref_want(ref_want), .main_want(main_want), .pick(mux_pick), .pd_req(pd_req));

  pd_sequencer #(.PERSIST_CYC(PERSIST_CYC), .SETTLE_CYC(SETTLE_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .outs_off(&hiz_v),
    .run_ok(run_ok), .down(pwr_down));

  assign src_v  = {lvl_main, mux_pick ? lvl_pre : lvl_mast};
  assign want_v = {main_want & run_ok, ref_want & run_ok};

  for (genvar g = 0; g < NPIN; g++) begin : g_gate
    out_gate gate_i (
      .clk(clk), .rst_n(rst_n), .src(src_v[g]), .want(want_v[g]),
      .out_q(out_v[g]), .hiz_q(hiz_v[g]));
  end

  assign out0     = out_v[0];
  assign out1     = out_v[1];
  assign out0_hiz = hiz_v[0];
  assign out1_hiz = hiz_v[1];

  assert_drained_before_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> out0_hiz && out1_hiz);

  assert_settle_after_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> out0_hiz && out1_hiz);
endmodule

// File: tb/clkout_ctrl_tb.sv
module clkout_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PERSIST    = 6;
  localparam int SETTLE     = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc = 0;
  logic ctl0_pin = 0, ctl1_pin = 0;
  logic cfg_en0 = 1, cfg_sel0 = 1, cfg_pdn0 = 0, cfg_pdn1 = 0;
  logic lvl_mast, lvl_pre, lvl_main;
  logic out0, out0_hiz, out1, out1_hiz, mux_pick, pwr_down;
  int   total = 0, bad = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit s_mast(int c); return (c % 2) == 1; endfunction
  function automatic bit s_pre(int c);  return ((c / 4) % 2) == 1; endfunction
  function automatic bit s_main(int c); return (c % 6) < 3; endfunction

  assign lvl_mast = s_mast(cyc);
  assign lvl_pre  = s_pre(cyc);
  assign lvl_main = s_main(cyc);

  initial forever begin
    @(posedge clk); #1; cyc = cyc + 1;
  end

  clkout_ctrl #(.SYNC_STAGES(2), .PERSIST_CYC(PERSIST), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .lvl_mast(lvl_mast), .lvl_pre(lvl_pre), .lvl_main(lvl_main),
    .ctl0_pin(ctl0_pin), .ctl1_pin(ctl1_pin), .cfg_en0(cfg_en0), .cfg_sel0(cfg_sel0),
    .cfg_pdn0(cfg_pdn0), .cfg_pdn1(cfg_pdn1), .out0(out0), .out0_hiz(out0_hiz),
    .out1(out1), .out1_hiz(out1_hiz), .mux_pick(mux_pick), .pwr_down(pwr_down));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // compare an output against its source one cycle late, over a window
  task automatic track(input bit which, input bit pre, input string tag);
    int miss = 0;
    int last_a = 0, last_e = 0;
    for (int i = 0; i < 12; i++) begin
      bit e, a;
      @(negedge clk);
      if (which) begin e = s_main(cyc - 1); a = out1; end
      else begin e = pre ? s_pre(cyc - 1) : s_mast(cyc - 1); a = out0; end
      if (a != e) begin miss++; last_a = a; last_e = e; end
    end
    chk(miss == 0, tag, last_a, last_e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    @(negedge clk);
    chk(out0_hiz && out1_hiz && !pwr_down, "R9 reset state", {out0_hiz, out1_hiz, pwr_down}, 6);
    rst_n = 1'b1;
    tick(10);
    @(negedge clk);
    chk(out0_hiz && out1_hiz, "R9 settle after reset", {out0_hiz, out1_hiz}, 3);
    tick(40);
    @(negedge clk);
    chk(!out0_hiz && !out1_hiz, "R9 running after settle", {out0_hiz, out1_hiz}, 0);

    // pin 0 modes: every bit combination and pin level
    for (int k = 0; k < 16; k++) begin
      bit e, s, p, c, pd, en, pk;
      string tag;
      e = k[0]; s = k[1]; p = k[2]; c = k[3];
      pd = c & (p | (!e & !s));
      en = !pd & (p ? 1'b1 : (e ? !c : s));
      pk = (!e & s & !p) ? c : s;
      tag = p ? "R1" : (e ? "R2" : (s ? "R3" : "R4"));
      cfg_en0 = e; cfg_sel0 = s; cfg_pdn0 = p; ctl0_pin = c;
      tick(60);
      @(negedge clk);
      chk(pwr_down == pd, {tag, " R6 shutdown"}, pwr_down, pd);
      chk(out0_hiz == !en, {tag, " ref hiz"}, out0_hiz, !en);
      if (!pd) chk(mux_pick == pk, {tag, " mux pick"}, mux_pick, pk);
      else chk(out1_hiz == 1'b1, "R8 main drained", out1_hiz, 1);
      if (en) track(1'b0, pk, {tag, " R7 ref follows source"});
      ctl0_pin = 0;
      tick(60);
    end

    // pin 1 modes
    cfg_en0 = 1; cfg_sel0 = 1; cfg_pdn0 = 0; ctl0_pin = 0;
    for (int k = 0; k < 4; k++) begin
      bit p1, c1, pd, en;
      p1 = k[0]; c1 = k[1];
      pd = p1 & c1;
      en = !pd & (p1 ? 1'b1 : !c1);
      cfg_pdn1 = p1; ctl1_pin = c1;
      tick(60);
      @(negedge clk);
      chk(pwr_down == pd, "R5 pin1 shutdown", pwr_down, pd);
      chk(out1_hiz == !en, "R5 main hiz", out1_hiz, !en);
      if (pd) chk(out0_hiz == 1'b1, "R8 ref drained", out0_hiz, 1);
      if (en) track(1'b1, 1'b0, "R7 main follows source");
      ctl1_pin = 0;
      tick(60);
    end

    // both pins configured as shutdown: either one alone suffices
    cfg_pdn0 = 1; cfg_pdn1 = 1; ctl1_pin = 1;
    tick(40);
    @(negedge clk);
    chk(pwr_down == 1'b1, "R6 OR via pin1", pwr_down, 1);
    ctl1_pin = 0;
    tick(60);
    @(negedge clk);
    chk(pwr_down == 1'b0, "R6 released", pwr_down, 0);

    // short request below threshold is ignored
    begin
      int seen = 0;
      ctl1_pin = 1; tick(3); ctl1_pin = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (pwr_down || out1_hiz) seen++;
      end
      chk(seen == 0, "R10 short request ignored", seen, 0);
    end

    // long request, then settle window after exit
    ctl1_pin = 1;
    tick(30);
    @(negedge clk);
    chk(pwr_down && out0_hiz && out1_hiz, "R8 down with outputs off", pwr_down, 1);
    ctl1_pin = 0;
    tick(12);
    @(negedge clk);
    chk(!pwr_down && out0_hiz && out1_hiz, "R9 settle after exit", {pwr_down, out0_hiz, out1_hiz}, 3);
    tick(40);
    @(negedge clk);
    chk(!out0_hiz && !out1_hiz, "R9 running after exit", {out0_hiz, out1_hiz}, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule